// File: doc/BRIEF.md
# Serial Slave Readout Port for a Data Converter

This block is the converter-facing end of a serial link in which the host supplies the bit clock. A finished conversion is presented as a one-cycle `conv_done` strobe with the raw code on `conv_data`. The block captures that code into a shift register, in offset binary or two's complement form. It then moves the word out most significant bit first on `sdout`, one bit for each active edge of the external `sclk`. Everything runs on the system clock `clk`. The serial clock is sampled and its edges are found by comparing it with its value in the previous cycle.

The active edge can be chosen: rising edges advance the data when `sclk_inv` is low, and falling edges do so when it is high. Edges count only while `cs_n` is low. The data line is enabled only while both `cs_n` and `rd_n` are low; otherwise this model drives it low. Each shift pulls the level on `sdin` into the bottom of the register. The upstream bit therefore reaches `sdout` exactly one word length later, so several converters can share one output line in a chain.

If a new conversion completes while a read has moved out some bits but not the whole word, the unread bits are dropped and `rd_err` pulses for one system clock cycle.

Top module: `adc_serial_slave_port`

## Requirements
- R1: The shift register loads only in the cycle `conv_done` is high. From the following cycle the enabled `sdout` carries bit 15 of the loaded word, and each later active edge moves to the next lower bit.
- R2: With `sclk_inv` = 0 a rising `sclk` edge advances the data. With `sclk_inv` = 1 a falling edge advances it. The other edge has no effect.
- R3: While `cs_n` is high, `sclk` edges neither shift data nor advance the bit count. A later read returns the word unchanged.
- R4: `sdout_en` is high exactly when `cs_n` and `rd_n` are both low. Otherwise `sdout` is 0. Reset leaves `sdout` and `rd_err` at 0.
- R5: The level on `sdin` at an active edge appears on `sdout` after 16 active edges in total, counted from the first one. This makes a 32-edge read return the local word followed by the upstream word.
- R6: If `conv_done` arrives after 1 to 15 active edges of the current read, `rd_err` is high for exactly the next cycle. It does not rise after 0 edges or after a complete 16-edge read.
- R7: With `fmt_twos` = 1 the loaded word is `conv_data` with bit 15 inverted. With `fmt_twos` = 0 it is `conv_data` unchanged.
- R8: A rising `cs_n` clears the bit count. A read abandoned part-way and followed by `conv_done` does not raise `rd_err`.
- R9: When `conv_done` and an active edge fall in the same cycle, the load takes priority: the new MSB is on `sdout` and the bit count restarts at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_done | input | 1 | One-cycle strobe marking a finished conversion |
| conv_data | input | 16 | Offset-binary conversion code |
| fmt_twos | input | 1 | 1 selects two's complement presentation |
| sclk_inv | input | 1 | 0 selects rising update edge, 1 selects falling |
| cs_n | input | 1 | Active-low select, gates the serial clock |
| rd_n | input | 1 | Active-low read enable for the data line |
| sclk | input | 1 | External serial bit clock |
| sdin | input | 1 | Serial input from the upstream converter in a chain |
| sdout | output | 1 | Serial data out, MSB first |
| sdout_en | output | 1 | High while the data line is enabled |
| rd_err | output | 1 | One-cycle pulse on an incomplete read |

## Verification
The assertions assume that `sclk` is slow against `clk` and holds each level for at least one system cycle, so every edge is seen once. They also assume `conv_done` is a single-cycle strobe and that `sclk` sits low through reset. The bench meets these conditions by holding each serial clock level for two system cycles. It raises `conv_done` for one cycle at a time and keeps `sclk` low until reset is released. The edge-polarity changes are made only while `cs_n` is high, so a polarity change never creates an edge.

// File: rtl/adc_serial_slave_port.sv
module adc_serial_slave_port #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_done,
  input  logic [WIDTH-1:0] conv_data,
  input  logic             fmt_twos,
  input  logic             sclk_inv,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             sclk,
  input  logic             sdin,
  output logic             sdout,
  output logic             sdout_en,
  output logic             rd_err
);

  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] FULL = CW'(WIDTH);

  logic             sclk_q;
  logic             cs_q;
  logic [WIDTH-1:0] sr;
  logic [CW-1:0]    cnt;

  wire sclk_rise = sclk & ~sclk_q;
  wire sclk_fall = ~sclk & sclk_q;
  wire upd       = ~cs_n & (sclk_inv ? sclk_fall : sclk_rise);
  wire cs_rise   = cs_n & ~cs_q;
  wire partial   = (cnt != '0) && (cnt < FULL);

  wire [WIDTH-1:0] coded = fmt_twos ? {~conv_data[WIDTH-1], conv_data[WIDTH-2:0]}
                                    : conv_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      sr     <= '0;
      cnt    <= '0;
      rd_err <= 1'b0;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs_n;
      rd_err <= conv_done & partial;
      if (conv_done) begin
        sr  <= coded;
        cnt <= '0;
      end else begin
        if (upd) sr <= {sr[WIDTH-2:0], sdin};
        if (cs_rise)                 cnt <= '0;
        else if (upd && cnt != FULL) cnt <= cnt + 1'b1;
      end
    end
  end

  assign sdout_en = ~cs_n & ~rd_n;
  assign sdout    = sdout_en & sr[WIDTH-1];

  p_err_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |=> !rd_err);

  p_err_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> $past(conv_done));

  p_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !conv_done) |=> (sr == $past(sr)));

  p_load_msb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> (sr[WIDTH-1] == ($past(conv_data[WIDTH-1]) ^ $past(fmt_twos))));

  p_cnt_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cs_n) && !conv_done) |=> (cnt == '0));

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);

endmodule

// File: tb/sim_adc_serial_slave_port.sv
module sim_adc_serial_slave_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conv_done = 1'b0;
  logic [15:0] conv_data = '0;
  logic fmt_twos = 1'b0, sclk_inv = 1'b0, cs_n = 1'b1, rd_n = 1'b1, sclk = 1'b0, sdin = 1'b0;
  logic sdout, sdout_en, rd_err;

  int checks = 0, fails = 0, cycles = 0;
  string phase = "R4";

  always #5 clk = ~clk;

  adc_serial_slave_port #(.WIDTH(16)) u0 (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_data(conv_data),
    .fmt_twos(fmt_twos), .sclk_inv(sclk_inv), .cs_n(cs_n), .rd_n(rd_n),
    .sclk(sclk), .sdin(sdin), .sdout(sdout), .sdout_en(sdout_en), .rd_err(rd_err));

  // behavioural reference
  bit q[$];
  int m_cnt;
  bit m_err, m_sclk, m_cs;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      for (int i = 0; i < 16; i++) q.push_back(1'b0);
      m_cnt = 0; m_err = 0; m_sclk = 0; m_cs = 1;
    end else begin
      bit edge_ok;
      logic [15:0] w;
      edge_ok = !cs_n && (sclk_inv ? (m_sclk && !sclk) : (!m_sclk && sclk));
      m_err = conv_done && m_cnt > 0 && m_cnt < 16;
      if (conv_done) begin
        w = fmt_twos ? (conv_data ^ 16'h8000) : conv_data;
        q.delete();
        for (int i = 15; i >= 0; i--) q.push_back(w[i]);
        m_cnt = 0;
      end else begin
        if (edge_ok) begin
          void'(q.pop_front());
          q.push_back(sdin);
        end
        if (cs_n && !m_cs) m_cnt = 0;
        else if (edge_ok && m_cnt < 16) m_cnt++;
      end
      m_sclk = sclk; m_cs = cs_n;
    end
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles, expected under 100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    bit en;
    en = !cs_n && !rd_n;
    chk(phase, sdout_en, en, "sdout_en (R4)");
    chk(phase, sdout, en ? q[0] : 1'b0, "sdout");
    chk(phase, rd_err, m_err, "rd_err");
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic load(logic [15:0] d, logic twos);
    conv_data = d; fmt_twos = twos; conv_done = 1'b1;
    step(1);
    conv_done = 1'b0;
  endtask

  task automatic start(logic inv);
    cs_n = 1'b1; step(1);
    sclk_inv = inv; sclk = inv; step(2);
    cs_n = 1'b0; rd_n = 1'b0; step(2);
  endtask

  task automatic shift(int n, logic [31:0] din, output logic [31:0] got);
    got = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      got = {got[30:0], sdout};
      step(1);
      sdin = din[31-i];
      sclk = ~sclk_inv; step(2);
      sclk = sclk_inv;  step(2);
    end
  endtask

  task automatic stop();
    cs_n = 1'b1; rd_n = 1'b1; step(2);
  endtask

  task automatic word_chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s word: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    logic [31:0] got;
    step(4);
    chk("R4", sdout, 1'b0, "reset sdout");
    chk("R4", rd_err, 1'b0, "reset rd_err");
    rst_n = 1'b1; step(2);

    phase = "R1";
    load(16'hA5C3, 1'b0);
    start(1'b0); shift(16, 32'h0, got); stop();
    word_chk("R1 R2 rising", got[15:0], 16'hA5C3);

    phase = "R7";
    load(16'h1234, 1'b1);
    start(1'b1); shift(16, 32'h0, got); stop();
    word_chk("R7 R2 falling", got[15:0], 16'h9234);
    load(16'h8001, 1'b1);
    start(1'b0); shift(16, 32'h0, got); stop();
    word_chk("R7 negative", got[15:0], 16'h0001);

    phase = "R3";
    load(16'h5A0F, 1'b0);
    for (int i = 0; i < 5; i++) begin sclk = 1'b1; step(2); sclk = 1'b0; step(2); end
    start(1'b0); shift(16, 32'h0, got); stop();
    word_chk("R3 gated clock", got[15:0], 16'h5A0F);

    phase = "R4";
    load(16'hFFFF, 1'b0);
    cs_n = 1'b0; rd_n = 1'b1; step(2);
    chk("R4", sdout, 1'b0, "rd_n high sdout");
    chk("R4", sdout_en, 1'b0, "rd_n high enable");
    stop();

    phase = "R5";
    load(16'hC3A5, 1'b0);
    start(1'b0); shift(32, 32'h6E1B_0000, got); stop();
    word_chk("R5 daisy", got, 32'hC3A5_6E1B);

    phase = "R6";
    load(16'hAAAA, 1'b0);
    start(1'b0); shift(5, 32'h0, got);
    conv_data = 16'h0F0F; conv_done = 1'b1; step(1); conv_done = 1'b0;
    @(negedge clk); chk("R6", rd_err, 1'b1, "partial read pulse");
    step(1);
    @(negedge clk); chk("R6", rd_err, 1'b0, "pulse one cycle");
    stop();
    start(1'b0); shift(16, 32'h0, got);
    word_chk("R6 discard", got[15:0], 16'h0F0F);
    load(16'h1111, 1'b0);
    @(negedge clk); chk("R6", rd_err, 1'b0, "complete read no error");
    stop();

    phase = "R8";
    start(1'b0); shift(7, 32'h0, got); stop();
    load(16'h2222, 1'b0);
    @(negedge clk); chk("R8", rd_err, 1'b0, "abandoned read no error");

    phase = "R9";
    start(1'b0); shift(3, 32'h0, got);
    conv_data = 16'h8000; conv_done = 1'b1; sclk = 1'b1; step(1);
    conv_done = 1'b0; step(1); sclk = 1'b0; step(2);
    @(negedge clk); chk("R9", sdout, 1'b1, "load wins over edge");
    shift(16, 32'h0, got); stop();
    word_chk("R9 restart", got[15:0], 16'h8000);

    step(4);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule